// File: doc/BRIEF.md
# Single-Frame Video Capture into Asynchronous SRAM

The block takes the digital output of a video digitizer (a pixel clock, horizontal and vertical sync, and one 8-bit sample per clock) and stores one complete frame in an external byte-wide asynchronous SRAM. A host asks for a capture by raising a request line. The block waits for the next start of frame and writes every pixel of the active window once, in raster order. It then raises a done flag and leaves the memory alone until the next request.

The host later reads the stored frame back through slow general-purpose IO lines. Each rising edge of a read strobe brings the next stored byte onto an 8-bit output. A rewind line moves the read position back to the first pixel. The host lines are asynchronous to the pixel clock and may toggle at any rate that leaves each level in place for a few pixel clocks.

The whole block runs on the pixel clock, nominally 25.175 MHz. The falling edge of that clock times the second half of each memory access: the write-enable pulse and the latching of read data. The active window size and the blanking offsets from the sync edges are parameters, with a default of 640×480 pixels in a 19-bit address space.

Top module: `frame_grabber`

## Requirements
- R1: After reset, busy and done are low, the SRAM chip-enable, write-enable and output-enable (all active low) are high, the data bus is released and the host data output is 0x00.
- R2: A rising edge on the capture request (taken through a two-flop synchronizer) while idle or done raises busy. No SRAM write happens until the next rising edge of vertical sync.
- R3: Syncs are active high. Line n is the n-th horizontal sync rising edge after the line holding the vertical sync rising edge (that line is 0). Column c is sampled H_BP+1+c clocks after a horizontal sync rising edge. Pixels with c below ACT_W on lines V_BP to V_BP+ACT_H-1 are stored at address (n-V_BP)*ACT_W+c. No other sample is stored.
- R4: Exactly ACT_W*ACT_H writes are made per capture. Done then rises and busy falls in the same cycle, and later frames write nothing.
- R5: Write-enable is low only while the pixel clock is low, and only with chip-enable low. The SRAM address does not change while write-enable is low.
- R6: Each synchronized rising edge of the read strobe while not busy puts the byte at the read position on the data output and advances the position by one. The position starts at zero after reset.
- R7: While the synchronized rewind line is high and the block is not busy, the read position is zero, so the next strobe returns the byte at address 0.
- R8: While busy, read strobes and rewind are ignored. The data output and the read position keep their values.
- R9: A new request after done clears done, raises busy and captures a fresh frame over the old contents.
- R10: Reading gives the same byte sequence whether the strobe toggles every 4 pixel clocks or every 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock from the digitizer; clocks the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| pix | input | 8 | Pixel sample, valid on each rising clock edge |
| sram_addr | output | ADDR_W | SRAM address |
| sram_data | inout | 8 | SRAM data bus, driven only during writes |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| cap_req | input | 1 | Host capture request; a rising edge arms a capture |
| cap_busy | output | 1 | High from arming until the frame is stored |
| cap_done | output | 1 | High once a full frame is stored |
| rd_strobe | input | 1 | Host read strobe; each rising edge fetches the next byte |
| rd_rewind | input | 1 | Host level that returns the read position to zero |
| rd_data | output | 8 | Last byte fetched for the host |

## Verification
A wrong pixel or line counter shows up as a shifted, clipped or stretched image in the SRAM model. It can be seen as soon as the first active line is written, because the bench puts an address-coded pattern in the window and a distinct filler value outside it. A wrong capture state shows up as writes before the vertical sync, as a write count other than one frame, or as done never rising. A wrong read position or a read that ignores busy shows up at the host data output on the very next strobe. Write-enable timing is sampled in the high and low half of every clock, so a misplaced pulse is seen in the cycle where it happens.

// File: rtl/frame_grabber.sv
module frame_grabber #(
  parameter int ADDR_W = 19,
  parameter int ACT_W  = 640,
  parameter int ACT_H  = 480,
  parameter int H_BP   = 144,
  parameter int V_BP   = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [7:0]        pix,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [7:0]        sram_data,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  input  logic              cap_req,
  output logic              cap_busy,
  output logic              cap_done,
  input  logic              rd_strobe,
  input  logic              rd_rewind,
  output logic [7:0]        rd_data
);

  localparam int FRAME = ACT_W * ACT_H;
  localparam int HC_W  = $clog2(H_BP + ACT_W + 2);
  localparam int VC_W  = $clog2(V_BP + ACT_H + 2);

  typedef enum logic [1:0] {IDLE, ARMED, CAPT, DONE} st_t;
  st_t st;

  logic hs_q, vs_q;
  logic [HC_W-1:0] hcnt;
  logic [VC_W-1:0] lcnt;

  wire hs_rise = hsync & ~hs_q;
  wire vs_rise = vsync & ~vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      hcnt <= '1;
      lcnt <= '1;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (hs_rise) hcnt <= '0;
      else if (hcnt != '1) hcnt <= hcnt + 1'b1;
      if (vs_rise) lcnt <= '0;
      else if (hs_rise && lcnt != '1) lcnt <= lcnt + 1'b1;
    end
  end

  wire in_win = (hcnt >= HC_W'(H_BP)) && (hcnt < HC_W'(H_BP + ACT_W)) &&
                (lcnt >= VC_W'(V_BP)) && (lcnt < VC_W'(V_BP + ACT_H));

  logic [2:0] req_s, stb_s;
  logic [1:0] rew_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s <= '0;
      stb_s <= '0;
      rew_s <= '0;
    end else begin
      req_s <= {req_s[1:0], cap_req};
      stb_s <= {stb_s[1:0], rd_strobe};
      rew_s <= {rew_s[0], rd_rewind};
    end
  end

  wire req_rise = req_s[1] & ~req_s[2];
  wire stb_rise = stb_s[1] & ~stb_s[2];

  assign cap_busy = (st == ARMED) || (st == CAPT);
  assign cap_done = (st == DONE);

  logic              wr_v;
  logic [ADDR_W-1:0] wr_addr, wptr;
  logic [7:0]        wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      wptr    <= '0;
      wr_v    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_v <= 1'b0;
      case (st)
        IDLE, DONE: if (req_rise) st <= ARMED;
        ARMED: if (vs_rise) begin
          st   <= CAPT;
          wptr <= '0;
        end
        CAPT: if (in_win) begin
          wr_v    <= 1'b1;
          wr_addr <= wptr;
          wr_data <= pix;
          wptr    <= wptr + 1'b1;
          if (wptr == ADDR_W'(FRAME - 1)) st <= DONE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic              rd_go;
  logic [ADDR_W-1:0] rd_ptr;
  wire start_rd = stb_rise & ~cap_busy & ~req_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_go  <= 1'b0;
      rd_ptr <= '0;
    end else begin
      rd_go <= start_rd;
      if (!cap_busy && rew_s[1]) rd_ptr <= '0;
      else if (rd_go) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_go) rd_data <= sram_data;
  end

  assign sram_addr = wr_v ? wr_addr : rd_ptr;
  assign sram_data = wr_v ? wr_data : 8'hzz;
  assign sram_we_n = ~(wr_v & ~clk);
  assign sram_oe_n = ~rd_go;
  assign sram_ce_n = ~(wr_v | rd_go);

  logic [ADDR_W-1:0] addr_neg;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) addr_neg <= '0;
    else addr_neg <= sram_addr;
  end

  // R5
  we_high_half_chk: assert property (@(negedge clk) disable iff (!rst_n)
    sram_we_n);

  // R5
  we_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_addr == addr_neg) && !sram_ce_n);

  // R4
  no_write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> sram_we_n);

  // R8
  no_read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_busy |-> sram_oe_n);

  // R6
  read_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> sram_we_n && !sram_ce_n);

  // R2
  armed_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_busy) |-> sram_we_n && sram_oe_n);

endmodule

// File: tb/test_frame_grabber.sv
module test_frame_grabber;
  localparam int CLK_P = 40;
  localparam int AW = 8, W = 8, H = 4, HB = 3, VB = 2;
  localparam int LINE = 16, LINES = 8, FR = W * H;

  logic clk = 0, rst_n = 0, hsync = 0, vsync = 0;
  logic [7:0] pix = 0;
  logic cap_req = 0, rd_strobe = 0, rd_rewind = 0;
  wire [AW-1:0] sram_addr;
  wire [7:0] sram_data;
  wire sram_ce_n, sram_we_n, sram_oe_n, cap_busy, cap_done;
  wire [7:0] rd_data;

  int checks = 0, errors = 0, nwr = 0, we_bad = 0;
  bit fin = 0;
  logic [7:0] mem [0:(1<<AW)-1];

  always #(CLK_P/2) clk = ~clk;

  frame_grabber #(.ADDR_W(AW), .ACT_W(W), .ACT_H(H), .H_BP(HB), .V_BP(VB)) i_frame_grabber (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .pix(pix),
    .sram_addr(sram_addr), .sram_data(sram_data), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .cap_req(cap_req),
    .cap_busy(cap_busy), .cap_done(cap_done), .rd_strobe(rd_strobe),
    .rd_rewind(rd_rewind), .rd_data(rd_data));

  assign sram_data = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr] : 8'hzz;

  always @(negedge clk) begin
    #(CLK_P/4);
    if (!sram_we_n) begin
      if (sram_ce_n) we_bad++;
      mem[sram_addr] = sram_data;
      nwr++;
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && sram_we_n !== 1'b1) we_bad++;
  end

  function automatic logic [7:0] pat(input logic [7:0] s, input int idx);
    return {4'(idx / W), 4'(idx % W)} ^ s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_line(input int l, input bit vs, input logic [7:0] s);
    for (int t = 0; t < LINE; t++) begin
      @(negedge clk);
      hsync = (t < 2);
      vsync = vs && (l == 0) && (t >= 2) && (t < 5);
      if (l >= VB && l < VB + H && t >= HB + 1 && t < HB + 1 + W)
        pix = pat(s, (l - VB) * W + (t - HB - 1));
      else
        pix = 8'hEE;
    end
  endtask

  task automatic drive_frame(input logic [7:0] s);
    for (int l = 0; l < LINES; l++) drive_line(l, 1'b1, s);
  endtask

  task automatic pulse(ref logic sig, input int hold);
    @(negedge clk); sig = 1;
    repeat (hold) @(negedge clk);
    sig = 0;
    repeat (hold) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 busy", cap_busy, 0);
    chk("R1 done", cap_done, 0);
    chk("R1 we_n", sram_we_n, 1);
    chk("R1 oe_n", sram_oe_n, 1);
    chk("R1 ce_n", sram_ce_n, 1);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_capture(input logic [7:0] s);
    pulse(cap_req, 4);
    chk("R2 busy after request", cap_busy, 1);
    chk("R2 done after request", cap_done, 0);
    drive_line(3, 1'b0, s);
    chk("R2 no write before vsync", nwr, 0);
    chk("R2 mem untouched", mem[0], 8'hA5);
    drive_frame(s);
    chk("R4 done", cap_done, 1);
    chk("R4 not busy", cap_busy, 0);
    chk("R4 write count", nwr, FR);
    for (int i = 0; i < FR; i++) chk("R3 stored pixel", mem[i], pat(s, i));
    chk("R3 nothing past frame", mem[FR], 8'hA5);
    drive_frame(s ^ 8'hFF);
    chk("R4 later frame writes nothing", nwr, FR);
    chk("R4 contents kept", mem[5], pat(s, 5));
  endtask

  task automatic t_read(input logic [7:0] s);
    pulse(rd_rewind, 4);
    for (int k = 0; k < 10; k++) begin
      pulse(rd_strobe, 4);
      chk("R6 R10 fast read", rd_data, pat(s, k));
    end
    for (int k = 10; k < 13; k++) begin
      pulse(rd_strobe, 40);
      chk("R10 slow read", rd_data, pat(s, k));
    end
    pulse(rd_rewind, 4);
    pulse(rd_strobe, 4);
    chk("R7 rewind to zero", rd_data, pat(s, 0));
    pulse(rd_strobe, 4);
    pulse(rd_strobe, 4);
    chk("R6 position 2", rd_data, pat(s, 2));
  endtask

  task automatic t_busy(input logic [7:0] s_old, input logic [7:0] s);
    pulse(cap_req, 4);
    chk("R9 done cleared", cap_done, 0);
    chk("R9 busy again", cap_busy, 1);
    pulse(rd_strobe, 4);
    pulse(rd_rewind, 4);
    pulse(rd_strobe, 4);
    chk("R8 output held while busy", rd_data, pat(s_old, 2));
    drive_frame(s);
    chk("R9 done again", cap_done, 1);
    chk("R9 new frame first", mem[0], pat(s, 0));
    chk("R9 new frame last", mem[FR-1], pat(s, FR - 1));
    pulse(rd_strobe, 4);
    chk("R8 position kept while busy", rd_data, pat(s, 3));
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hA5;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_capture(8'h00);
    t_read(8'h00);
    t_busy(8'h00, 8'h5A);
    chk("R5 write enable timing", we_bad, 0);
    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule